// File: doc/BRIEF.md
# Memory Region Window Decoder

This block decides whether a host address lands in an address window that software has opened. A single 32-bit window-select register holds two enable masks. The upper half opens large regions of 256 MiB. Each one sits at a boundary set by the four most significant address bits, anywhere in the 4 GiB space. The lower half opens 16 MiB slices that exist only inside the topmost 256 MiB region. There, the next four address bits pick the slice.

Software programs the register through a small configuration write port. The port has an offset, 32-bit data and per-byte enables. The register starts out cleared, so nothing decodes until a window is opened. For every address, the block reports the result one clock later:
- a hit flag;
- a flag telling whether the match was a fine slice;
- the number of the matching region or slice.

Top module: `win_decoder`

## Requirements
- R1: After reset the select register is all zeros, and no address produces a hit.
- R2: A configuration write at offset 0x48 updates only the byte lanes whose enable is set. Lane i carries register bits 8i+7:8i, and lane 0 is bits 7:0. A write with no enables set changes nothing.
- R3: A configuration write to any offset other than 0x48 leaves the register unchanged.
- R4: Register bit 16+N opens the coarse region whose address bits 31:28 equal N. An address there, with no fine match, gives hit=1, hit_fine=0 and hit_index=N.
- R5: Register bit N (N in 0..15) opens the fine slice whose address bits 31:24 equal 0xF0+N. Such an address gives hit=1, hit_fine=1 and hit_index=N.
- R6: When an address matches both an open fine slice and the open coarse region 15, the fine match is reported.
- R7: Outputs are registered. The result for the address present at a rising clock edge appears after that edge and holds until the next edge. On a miss, hit_fine and hit_index are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_off | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data, little-endian lanes |
| cfg_be | input | 4 | Byte enables for the write data |
| host_addr | input | 32 | Host address to decode |
| hit | output | 1 | Address lies in an open window (registered) |
| hit_fine | output | 1 | Match came from a fine slice (registered) |
| hit_index | output | 4 | Region or slice number of the match (registered) |

## Verification
The bench builds the block with its default parameters: four coarse address bits, four fine address bits and a 32-bit select register. At this size every combination of the top eight address bits can be swept, which covers all 16 coarse regions and all 16 fine slices. Each sweep runs against several mask patterns, including ones where fine and coarse windows overlap, and after partial-byte writes and writes to the wrong offset. Expected results come from an arithmetic model of the mask. One targeted step checks that the outputs change only at a clock edge.

// File: rtl/wdec_pkg.sv
package wdec_pkg;
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_COARSE = 2'd1,
    SRC_FINE   = 2'd2
  } hit_src_e;
endpackage

// File: rtl/wdec_sel_reg.sv
module wdec_sel_reg #(
  parameter int REG_W  = 32,
  parameter int CFG_AW = 8,
  parameter logic [CFG_AW-1:0] OFFSET = 8'h48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CFG_AW-1:0] off,
  input  logic [REG_W-1:0]  wdata,
  input  logic [REG_W/8-1:0] be,
  output logic [REG_W-1:0]  sel_q
);
  localparam int LANES = REG_W / 8;

  logic sel_hit;
  assign sel_hit = wr && (off == OFFSET);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        sel_q[8*g +: 8] <= '0;
      else if (sel_hit && be[g])
        sel_q[8*g +: 8] <= wdata[8*g +: 8];
    end
  end

  // R1: register is clear on the cycle after reset
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sel_q == '0));

  // R3: writes to other offsets do not touch the register
  assert_wrong_off_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && off != OFFSET) |=> $stable(sel_q));

  // R2: a write without byte enables leaves the register as it was
  assert_no_be_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && be == '0) |=> $stable(sel_q));
endmodule

// File: rtl/wdec_coarse_match.sv
module wdec_coarse_match #(
  parameter int ADDR_W = 32,
  parameter int CB     = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [(1<<CB)-1:0] mask,
  output logic [(1<<CB)-1:0] vec
);
  localparam int NR = 1 << CB;

  logic [CB-1:0] region;
  assign region = addr[ADDR_W-1 -: CB];

  for (genvar g = 0; g < NR; g++) begin : g_reg
    assign vec[g] = mask[g] && (region == CB'(g));
  end
endmodule

// File: rtl/wdec_fine_match.sv
module wdec_fine_match #(
  parameter int ADDR_W = 32,
  parameter int CB     = 4,
  parameter int FB     = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [(1<<FB)-1:0] mask,
  output logic [(1<<FB)-1:0] vec
);
  localparam int NS = 1 << FB;

  logic          in_top;
  logic [FB-1:0] slice;
  assign in_top = &addr[ADDR_W-1 -: CB];
  assign slice  = addr[ADDR_W-1-CB -: FB];

  for (genvar g = 0; g < NS; g++) begin : g_slice
    assign vec[g] = in_top && mask[g] && (slice == FB'(g));
  end
endmodule

// File: rtl/wdec_onehot_enc.sv
module wdec_onehot_enc #(
  parameter int N = 16,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  output logic         any,
  output logic [W-1:0] idx
);
  assign any = |vec;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++)
      if (vec[i]) idx = W'(i);
  end
endmodule

// File: rtl/win_decoder.sv
module win_decoder #(
  parameter int ADDR_W = 32,
  parameter int CB     = 4,
  parameter int FB     = 4,
  parameter int CFG_AW = 8,
  parameter logic [CFG_AW-1:0] SEL_OFFSET = 8'h48,
  localparam int NC    = 1 << CB,
  localparam int NF    = 1 << FB,
  localparam int REG_W = NC + NF,
  localparam int IDX_W = (CB > FB) ? CB : FB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_off,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic [REG_W/8-1:0] cfg_be,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              hit,
  output logic              hit_fine,
  output logic [IDX_W-1:0]  hit_index
);
  import wdec_pkg::*;

  logic [REG_W-1:0] sel_q;
  logic [NC-1:0]    c_vec;
  logic [NF-1:0]    f_vec;
  logic             c_any, f_any;
  logic [CB-1:0]    c_idx;
  logic [FB-1:0]    f_idx;
  hit_src_e         src;
  logic [IDX_W-1:0] idx_d;

  wdec_sel_reg #(.REG_W(REG_W), .CFG_AW(CFG_AW), .OFFSET(SEL_OFFSET)) u_sel (
    .clk(clk), .rst(rst), .wr(cfg_wr), .off(cfg_off),
    .wdata(cfg_wdata), .be(cfg_be), .sel_q(sel_q)
  );

  wdec_coarse_match #(.ADDR_W(ADDR_W), .CB(CB)) u_coarse (
    .addr(host_addr), .mask(sel_q[REG_W-1 -: NC]), .vec(c_vec)
  );

  wdec_fine_match #(.ADDR_W(ADDR_W), .CB(CB), .FB(FB)) u_fine (
    .addr(host_addr), .mask(sel_q[NF-1:0]), .vec(f_vec)
  );

  wdec_onehot_enc #(.N(NC), .W(CB)) u_cenc (.vec(c_vec), .any(c_any), .idx(c_idx));
  wdec_onehot_enc #(.N(NF), .W(FB)) u_fenc (.vec(f_vec), .any(f_any), .idx(f_idx));

  // fine slices take priority over the enclosing coarse region
  always_comb begin
    if (f_any) begin
      src   = SRC_FINE;
      idx_d = IDX_W'(f_idx);
    end else if (c_any) begin
      src   = SRC_COARSE;
      idx_d = IDX_W'(c_idx);
    end else begin
      src   = SRC_NONE;
      idx_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit       <= 1'b0;
      hit_fine  <= 1'b0;
      hit_index <= '0;
    end else begin
      hit       <= (src != SRC_NONE);
      hit_fine  <= (src == SRC_FINE);
      hit_index <= idx_d;
    end
  end

  // R4: at most one coarse region can match a given address
  assert_coarse_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(c_vec));

  // R5: at most one fine slice can match a given address
  assert_fine_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(f_vec));

  // R6: overlapping coarse and fine matches report the fine one
  assert_fine_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (c_any && f_any) |=> (hit && hit_fine));

  // R7: a miss carries zero index and no fine flag
  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (!hit_fine && hit_index == '0));

  // R7: the outputs follow the address sampled at the previous edge
  assert_registered_R7: assert property (@(posedge clk) disable iff (rst)
    !(c_any || f_any) |=> !hit);
endmodule

// File: tb/win_decoder_test.sv
module win_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_off = 8'h00;
  logic [31:0] cfg_wdata = 32'h0;
  logic [3:0]  cfg_be = 4'h0;
  logic [31:0] host_addr = 32'h0;
  logic        hit, hit_fine;
  logic [3:0]  hit_index;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model = 32'h0;

  always #10 clk = ~clk;

  win_decoder uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_off(cfg_off),
    .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .host_addr(host_addr),
    .hit(hit), .hit_fine(hit_fine), .hit_index(hit_index)
  );

  function automatic logic [5:0] expect_of(logic [31:0] m, logic [31:0] a);
    int top = int'(a[31:28]);
    int sub = int'(a[27:24]);
    if (top == 15 && m[sub]) return {1'b1, 1'b1, 4'(sub)};
    if (m[16 + top])         return {1'b1, 1'b0, 4'(top)};
    return 6'b0;
  endfunction

  task automatic check(string req, logic [5:0] exp);
    checks++;
    if ({hit, hit_fine, hit_index} !== exp) begin
      fails++;
      $display("FAIL %s addr=%h mask=%h got hit=%b fine=%b idx=%0d exp hit=%b fine=%b idx=%0d",
               req, host_addr, model, hit, hit_fine, hit_index, exp[5], exp[4], exp[3:0]);
    end
  endtask

  task automatic cfg_write(logic [7:0] off, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_off = off; cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (off == 8'h48)
      for (int i = 0; i < 4; i++)
        if (be[i]) model[8*i +: 8] = d[8*i +: 8];
  endtask

  task automatic sweep(string req);
    for (int t = 0; t < 256; t++) begin
      host_addr = {8'(t), 24'($urandom)};
      @(negedge clk);
      check(req, expect_of(model, host_addr));
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset outputs", 6'b0);
    sweep("R1 cleared mask");

    cfg_write(8'h48, 32'h00A5_0000, 4'hF);
    sweep("R4 coarse only");

    cfg_write(8'h48, 32'h0000_8421, 4'hF);
    sweep("R5 fine only");

    cfg_write(8'h48, 32'h8003_0F0F, 4'hF);
    sweep("R6 fine over coarse");

    cfg_write(8'h48, 32'hFFFF_FFFF, 4'b0010);
    sweep("R2 single lane write");

    cfg_write(8'h48, 32'h0000_0000, 4'b0000);
    sweep("R2 no enables");

    cfg_write(8'h4C, 32'h0000_0000, 4'hF);
    sweep("R3 other offset");
    cfg_write(8'h00, 32'hFFFF_FFFF, 4'hF);
    sweep("R3 offset zero");

    cfg_write(8'h48, 32'h5A00_C300, 4'b1001);
    sweep("R2 outer lanes");

    // R7: output changes only at a clock edge
    cfg_write(8'h48, 32'h0001_0000, 4'hF);
    host_addr = 32'h0123_4567;
    @(negedge clk);
    check("R7 hit registered", 6'b10_0000);
    host_addr = 32'h2000_0000;
    #1;
    check("R7 held before edge", 6'b10_0000);
    @(negedge clk);
    check("R7 miss after edge", 6'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule